// File: doc/BRIEF.md
# Circular self-test register ring

This block is a ring of identical test cells meant to stand in for every storage element of a sequential design. Every flip-flop, primary input position and primary output position gets one cell. The cells feed the design's combinational logic through the state vector and take its responses back through the data vector. Two mode lines select how every cell loads on each clock:

- clear to zero;
- normal system capture;
- serial shift from an external scan input;
- self-test capture.

In self-test capture, each cell takes its own data bit XOR the output of the cell before it. The first cell's predecessor is the last cell, so the ring closes on itself. The whole chain is then one multiple-input signature register with feedback polynomial x^n + 1.

The ring runs the self-test at the system clock rate. Each cycle's state is the next test pattern for the logic. The responses it produces are compacted into the ring in the same cycle. After a chosen number of cycles, the ring holds a signature. That signature can be shifted out serially, or read in parallel, and compared elsewhere. The reset input clears the ring at once, and its release is synchronised to the clock.

Top module: `cbist_chain`

## Requirements
- R1: With mode = 2'b00 (bit 1 is B1, bit 0 is B0), every cell loads 0 on the next rising clock edge.
- R2: With mode = 2'b01, cell i loads sys_d[i] on the next rising clock edge.
- R3: With mode = 2'b10, cell i (i > 0) loads the old q_state[i-1] and cell 0 loads scan_in, so data moves from index 0 toward index WIDTH-1.
- R4: With mode = 2'b11, cell i (i > 0) loads sys_d[i] XOR the old q_state[i-1], and cell 0 loads sys_d[0] XOR the old q_state[WIDTH-1].
- R5: scan_out always equals q_state[WIDTH-1].
- R6: While rst_n is low, q_state is all zeros, without waiting for a clock edge. After rst_n rises, cells keep holding zero until the release has passed through SYNC_STAGES clock edges.
- R7: scan_in has no effect in modes 2'b01 and 2'b11.
- R8: A run of self-test cycles, with the logic under test connected from q_state to sys_d, ends in the signature given by repeated application of R4.
- R9: A single stuck-at-0 on one output of the example logic under test changes the final signature of the same run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Cell load mode, bit 1 = B1, bit 0 = B0 |
| sys_d | input | WIDTH | Response bits from the combinational logic, one per cell |
| scan_in | input | 1 | Serial input into cell 0 in shift mode |
| q_state | output | WIDTH | Ring state, driving the logic under test |
| scan_out | output | 1 | Serial output, last cell of the ring |

## Verification
The bench builds the ring with WIDTH = 12 and SYNC_STAGES = 2. With twelve cells, a full scan-out fits in a dozen cycles. The wrap from cell 11 back to cell 0 is seen on every self-test step. The example logic, which has taps at distances 1, 4 and 7, then reaches ring states that mix all positions. A 200-cycle signature run, both fault-free and with an injected stuck-at-0, compares the ring against a bench model of R4. The modest ring width makes the effect of a single fault on the signature practical to observe.

// File: rtl/cbist_pkg.sv
package cbist_pkg;

  typedef enum logic [1:0] {
    CB_CLEAR = 2'b00,
    CB_FUNC  = 2'b01,
    CB_SHIFT = 2'b10,
    CB_SIG   = 2'b11
  } cb_mode_e;

endpackage

// File: rtl/cbist_rst_sync.sv
module cbist_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cbist_cell.sv
module cbist_cell
  import cbist_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cb_mode_e mode,
  input  logic     d,
  input  logic     shift_src,
  input  logic     fb_src,
  output logic     q
);

  logic q_r;
  logic q_nxt;

  always_comb begin
    unique case (mode)
      CB_CLEAR: q_nxt = 1'b0;
      CB_FUNC:  q_nxt = d;
      CB_SHIFT: q_nxt = shift_src;
      default:  q_nxt = d ^ fb_src;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 1'b0;
    end else begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/cbist_ring.sv
module cbist_ring
  import cbist_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cb_mode_e         mode,
  input  logic [WIDTH-1:0] d,
  input  logic             scan_in,
  output logic [WIDTH-1:0] q
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] q_w;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    if (i == 0) begin : g_head
      cbist_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .d         (d[0]),
        .shift_src (scan_in),
        .fb_src    (q_w[LAST]),
        .q         (q_w[0])
      );
    end else begin : g_body
      cbist_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .d         (d[i]),
        .shift_src (q_w[i-1]),
        .fb_src    (q_w[i-1]),
        .q         (q_w[i])
      );
    end
  end

  assign q = q_w;

  // Support for checks: set once the ring has been out of reset for one edge.
  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
    end
  end

  logic [WIDTH-1:0] rot_q;
  logic [WIDTH-1:0] shf_q;
  assign rot_q = {q_w[LAST-1:0], q_w[LAST]};
  assign shf_q = {q_w[LAST-1:0], scan_in};

  // R1
  clear_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(mode) == CB_CLEAR) |-> (q_w == '0));

  // R2
  func_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(mode) == CB_FUNC) |-> (q_w == $past(d)));

  // R3
  shift_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(mode) == CB_SHIFT) |-> (q_w == $past(shf_q)));

  // R4
  sig_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(mode) == CB_SIG) |-> (q_w == ($past(d) ^ $past(rot_q))));

endmodule

// File: rtl/cbist_chain.sv
module cbist_chain
  import cbist_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] sys_d,
  input  logic             scan_in,
  output logic [WIDTH-1:0] q_state,
  output logic             scan_out
);

  logic     rst_n_i;
  cb_mode_e mode_e;

  assign mode_e = cb_mode_e'(mode);

  cbist_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  cbist_ring #(
    .WIDTH (WIDTH)
  ) u_ring (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .mode    (mode_e),
    .d       (sys_d),
    .scan_in (scan_in),
    .q       (q_state)
  );

  assign scan_out = q_state[WIDTH-1];

endmodule

// File: tb/cbist_chain_tb_top.sv
`timescale 1ns/1ps
module cbist_chain_tb_top;

  localparam int W = 12;
  localparam int SIG_CYCLES = 200;

  logic         clk;
  logic         rst_n;
  logic [1:0]   mode;
  logic [W-1:0] sys_d;
  logic [W-1:0] ext_d;
  logic         scan_in;
  logic [W-1:0] q_state;
  logic         scan_out;
  logic         use_cut;
  logic         fault_en;

  int checks;
  int errors;
  bit done;

  cbist_chain #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .sys_d    (sys_d),
    .scan_in  (scan_in),
    .q_state  (q_state),
    .scan_out (scan_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [W-1:0] rotl(input logic [W-1:0] v);
    return {v[W-2:0], v[W-1]};
  endfunction

  // Example logic under test, with an optional stuck-at-0 on output 5.
  function automatic logic [W-1:0] cut_fn(input logic [W-1:0] s, input logic flt);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = ~(s[(i+1)%W] & s[(i+4)%W]) ^ s[(i+7)%W];
    if (flt) r[5] = 1'b0;
    return r;
  endfunction

  always_comb sys_d = use_cut ? cut_fn(q_state, fault_en) : ext_d;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m);
    mode = m;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [W-1:0] v);
    use_cut = 1'b0;
    ext_d = v;
    step(2'b01);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mode = 2'b01;
    ext_d = '1;
    #1;
    check("R6 reset state", q_state, '0);
    check("R5 scan_out in reset", {{(W-1){1'b0}}, scan_out}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R6 held during sync", q_state, '0);
    @(posedge clk);
    @(negedge clk);
    check("R6 held during sync 2", q_state, '0);
    @(posedge clk);
    @(negedge clk);
    check("R6 released loads", q_state, '1);
  endtask

  task automatic t_system();
    logic [W-1:0] pats [4] = '{12'hA5C, 12'h3F0, 12'h001, 12'h800};
    for (int k = 0; k < 4; k++) begin
      scan_in = k[0];
      load(pats[k]);
      check("R2 system load", q_state, pats[k]);
      check("R7 scan_in ignored in system", q_state, pats[k]);
    end
  endtask

  task automatic t_clear();
    load(12'hFFF);
    step(2'b00);
    check("R1 clear", q_state, '0);
    load(12'h5A5);
    step(2'b00);
    check("R1 clear from pattern", q_state, '0);
  endtask

  task automatic t_shift();
    logic [W-1:0] model;
    logic [W-1:0] bits;
    bits = 12'hB37;
    load(12'hC81);
    model = 12'hC81;
    for (int k = 0; k < W; k++) begin
      scan_in = bits[k];
      step(2'b10);
      model = {model[W-2:0], bits[k]};
      check("R3 shift", q_state, model);
      check("R5 scan_out", {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, model[W-1]});
    end
  endtask

  task automatic t_sig_step();
    logic [W-1:0] model;
    load(12'h801);
    model = 12'h801;
    ext_d = '0;
    scan_in = 1'b0;
    step(2'b11);
    model = rotl(model);
    check("R4 ring wrap", q_state, model);
    scan_in = 1'b1;
    step(2'b11);
    model = rotl(model);
    check("R7 scan_in ignored in self-test", q_state, model);
    ext_d = 12'h6C3;
    step(2'b11);
    model = ext_d ^ rotl(model);
    check("R4 xor capture", q_state, model);
    ext_d = 12'hFFF;
    step(2'b11);
    model = ext_d ^ rotl(model);
    check("R4 xor capture ones", q_state, model);
  endtask

  task automatic run_sig(input logic flt, output logic [W-1:0] sig, output logic [W-1:0] model);
    use_cut = 1'b0;
    fault_en = flt;
    step(2'b00);
    model = '0;
    use_cut = 1'b1;
    for (int k = 0; k < SIG_CYCLES; k++) begin
      step(2'b11);
      model = cut_fn(model, flt) ^ rotl(model);
    end
    sig = q_state;
    use_cut = 1'b0;
    fault_en = 1'b0;
  endtask

  task automatic t_signature();
    logic [W-1:0] good_sig, good_model, bad_sig, bad_model;
    run_sig(1'b0, good_sig, good_model);
    check("R8 fault-free signature", good_sig, good_model);
    run_sig(1'b1, bad_sig, bad_model);
    check("R8 faulty signature model", bad_sig, bad_model);
    checks++;
    if (bad_sig === good_model) begin
      errors++;
      $display("FAIL R9: actual %h expected differing from %h", bad_sig, good_model);
    end
  endtask

  task automatic t_async_reset();
    load(12'h7E7);
    #2;
    rst_n = 1'b0;
    #1;
    check("R6 async clear", q_state, '0);
    @(negedge clk);
    rst_n = 1'b1;
    mode = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done = 0;
    rst_n = 1'b0;
    mode = 2'b00;
    ext_d = '0;
    scan_in = 1'b0;
    use_cut = 1'b0;
    fault_en = 1'b0;
    repeat (2) @(posedge clk);
    t_reset();
    t_system();
    t_clear();
    t_shift();
    t_sig_step();
    t_signature();
    t_async_reset();
    load(12'h123);
    check("R2 after async reset", q_state, 12'h123);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule